// File: doc/BRIEF.md
# Two-way set-associative tag directory with LRU

This block keeps the tag and status state of a two-way set-associative data cache with 128 sets. A 32-bit address is split, counting bits from the most significant end (bit 0 is the MSB), into a 20-bit tag in bits 0..19 and a 7-bit set index in bits 20..26. The low five bits select a word and byte within the line and play no part here. For every set the block stores, per way, one tag and one valid flag. Each set also has one least-recently-used bit that names the way to be replaced next.

A cache controller presents a lookup address. In the same cycle it gets back a hit flag, the way that hit and the replacement victim of the indexed set, all decoded from registered state. When a line fill has finished, the controller reports the completed fill with its address and way. That marks the line valid, stores its tag and points the LRU bit at the other way. A hitting lookup also points the LRU bit away from the way that hit. An invalidate request removes one line from one way of one set. The data array, the fill buffer and the bus side belong to the controller.

Top module: `tag_dir2w`

## Requirements
- R1: The tag is lk_addr[31:12] (address bits 0..19 in MSB-first numbering) and the set index is lk_addr[11:5] (bits 20..26). lk_addr[4:0] never changes any output, and the same rule applies to fill_addr.
- R2: After reset no lookup hits in any set, and lk_victim is 0 (way 0) for every set.
- R3: In the same cycle as lk_valid, lk_hit is 1 exactly when one way of the indexed set is valid and holds the lookup tag. lk_way then gives that way (0 or 1). With no hit, or with lk_valid low, both lk_hit and lk_way are 0.
- R4: lk_victim always equals the LRU bit of the set indexed by lk_addr, and its value is the number of the way to be replaced next.
- R5: A fill_valid cycle stores the fill tag in way fill_way of the fill set and marks that line valid from the next cycle on. It also sets that set's LRU bit to the way opposite fill_way.
- R6: A line is not valid before its fill is reported. A lookup in the same cycle as the fill of its line still misses.
- R7: A hitting lookup sets the LRU bit of its set to the way opposite lk_way from the next cycle on. A missing lookup leaves the LRU bit unchanged.
- R8: inv_valid clears the valid flag of way inv_way in set inv_idx. It leaves the other way and the LRU bit of that set unchanged.
- R9: When several requests meet in one cycle, a fill wins. A fill and an invalidate of the same line leave the line valid. A fill and a hitting lookup in the same set leave the LRU bit opposite fill_way.
- R10: Requests on one set never change the state of any other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_way | output | 1 | Way that hit (0 when no hit) |
| lk_victim | output | 1 | LRU way of the indexed set |
| fill_valid | input | 1 | Fill of a line has completed |
| fill_addr | input | 32 | Address of the filled line |
| fill_way | input | 1 | Way that received the line |
| inv_valid | input | 1 | Invalidate request |
| inv_idx | input | 7 | Set to invalidate |
| inv_way | input | 1 | Way to invalidate |

## Verification
Directed sequences on one set cover several cases: the first fill, a fill into the second way, hits that alternate between the ways, a miss on a third tag, and an invalidate. They tell apart an LRU bit that follows fills only from one that also follows hits. They also separate an invalidate that spares the LRU bit from one that disturbs it. Lookups that differ only in the low five bits, in the last tag bit or in the last index bit confirm the field boundaries. Fills issued together with an invalidate or a hit expose the fill-first ordering. Random traffic drawn from a small pool of tags and sets forces frequent hits, evictions and set collisions, including the extreme index values, and shows that sets stay separate.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  localparam int unsigned NUM_WAYS = 2;

  function automatic logic other_way(input logic way);
    return ~way;
  endfunction

endpackage

// File: rtl/tagdir_rstsync.sv
module tagdir_rstsync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/tagdir_way.sv
module tagdir_way #(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             match,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);

  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  vld_d;
  logic [TAG_W-1:0] tag_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (clr_en) begin
      vld_d[clr_idx] = 1'b0;
    end
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign match = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]); // R5

  AST_FILL_STORES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_tag))); // R5

  AST_INV_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(wr_en && (wr_idx == clr_idx))) |=> !vld_q[$past(clr_idx)]); // R8

  AST_FILL_BEATS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && wr_en && (wr_idx == clr_idx)) |=> vld_q[$past(clr_idx)]); // R9

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru
  import tagdir_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_lru,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_way
);

  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (acc_en) begin
      lru_d[acc_idx] = other_way(acc_way);
    end
    if (fill_en) begin
      lru_d[fill_idx] = other_way(fill_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      lru_q <= lru_d;
    end
  end

  assign rd_lru = lru_q[rd_idx];

  AST_FILL_LRU_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (lru_q[$past(fill_idx)] != $past(fill_way))); // R5

  AST_HIT_LRU_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !(fill_en && (fill_idx == acc_idx))) |=> (lru_q[$past(acc_idx)] != $past(acc_way))); // R7

  AST_IDLE_LRU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !fill_en) |=> (lru_q == $past(lru_q))); // R8

endmodule

// File: rtl/tag_dir2w.sv
module tag_dir2w
  import tagdir_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_way,
  output logic              lk_victim,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_way,
  input  logic              inv_valid,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              inv_way
);

  localparam int unsigned TAG_LSB = ADDR_W - TAG_W;
  localparam int unsigned IDX_LSB = TAG_LSB - IDX_W;

  logic                rst_sync_n;
  logic [TAG_W-1:0]    lk_tag;
  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    fl_tag;
  logic [IDX_W-1:0]    fl_idx;
  logic [NUM_WAYS-1:0] way_match;
  logic                any_match;
  logic                unused_offset;

  tagdir_rstsync u_rstsync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  assign lk_tag = lk_addr[ADDR_W-1:TAG_LSB];
  assign lk_idx = lk_addr[TAG_LSB-1:IDX_LSB];
  assign fl_tag = fill_addr[ADDR_W-1:TAG_LSB];
  assign fl_idx = fill_addr[TAG_LSB-1:IDX_LSB];
  assign unused_offset = ^{lk_addr[IDX_LSB-1:0], fill_addr[IDX_LSB-1:0]};

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic WSEL = (w == 1);
    logic wr_en;
    logic clr_en;

    assign wr_en  = fill_valid && (fill_way == WSEL);
    assign clr_en = inv_valid && (inv_way == WSEL);

    tagdir_way #(
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rd_idx  (lk_idx),
      .rd_tag  (lk_tag),
      .match   (way_match[w]),
      .wr_en   (wr_en),
      .wr_idx  (fl_idx),
      .wr_tag  (fl_tag),
      .clr_en  (clr_en),
      .clr_idx (inv_idx)
    );
  end

  assign any_match = |way_match;
  assign lk_hit    = lk_valid && any_match;
  assign lk_way    = lk_valid && way_match[1];

  tagdir_lru #(
    .IDX_W (IDX_W)
  ) u_lru (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (lk_idx),
    .rd_lru   (lk_victim),
    .acc_en   (lk_hit),
    .acc_idx  (lk_idx),
    .acc_way  (lk_way),
    .fill_en  (fill_valid),
    .fill_idx (fl_idx),
    .fill_way (fill_way)
  );

  AST_WAY_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_way |-> lk_hit); // R3

endmodule

// File: tb/test_tag_dir2w.sv
`timescale 1ns/1ps
module test_tag_dir2w;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic        lk_way;
  logic        lk_victim;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic        fill_way;
  logic        inv_valid;
  logic [6:0]  inv_idx;
  logic        inv_way;

  int checks;
  int fails;

  logic [19:0] m_tag [2][128];
  bit          m_vld [2][128];
  bit          m_lru [128];

  tag_dir2w i_tag_dir2w (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .lk_way     (lk_way),
    .lk_victim  (lk_victim),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_way   (fill_way),
    .inv_valid  (inv_valid),
    .inv_idx    (inv_idx),
    .inv_way    (inv_way)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit m_match(int w, logic [31:0] a);
    return m_vld[w][a[11:5]] && (m_tag[w][a[11:5]] == a[31:12]);
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lk, logic [31:0] la, bit fv, logic [31:0] fa,
                      bit fw, bit iv, int ii, bit iw);
    bit h0;
    bit h1;
    bit ehit;
    bit eway;
    @(negedge clk);
    lk_valid   = lk;
    lk_addr    = la;
    fill_valid = fv;
    fill_addr  = fa;
    fill_way   = fw;
    inv_valid  = iv;
    inv_idx    = 7'(ii);
    inv_way    = iw;
    #1;
    h0   = m_match(0, la);
    h1   = m_match(1, la);
    ehit = lk && (h0 || h1);
    eway = lk && h1;
    check(req, "lk_hit", lk_hit, ehit);
    check(req, "lk_way", lk_way, eway);
    check(req, "lk_victim", lk_victim, m_lru[la[11:5]]);
    if (ehit) m_lru[la[11:5]] = ~eway;
    if (iv) m_vld[iw][ii] = 1'b0;
    if (fv) begin
      m_vld[fw][fa[11:5]] = 1'b1;
      m_tag[fw][fa[11:5]] = fa[31:12];
      m_lru[fa[11:5]]     = ~fw;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid   = 1'b0;
    fill_valid = 1'b0;
    inv_valid  = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [31:0] A  = 32'hABCDE060;
  localparam logic [31:0] AL = 32'hABCDE07F;
  localparam logic [31:0] AT = 32'hABCDF060;
  localparam logic [31:0] AI = 32'hABCDE040;
  localparam logic [31:0] B  = 32'h12345060;
  localparam logic [31:0] C  = 32'h55555060;
  localparam logic [31:0] N  = 32'h0;

  initial begin
    logic [19:0] tpool [4];
    int          spool [4];
    void'($urandom(32'd1357));
    checks = 0;
    fails  = 0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 128; s++) begin
        m_vld[w][s] = 1'b0;
        m_tag[w][s] = '0;
      end
    for (int s = 0; s < 128; s++) m_lru[s] = 1'b0;
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_addr = '0; fill_valid = 1'b0; fill_addr = '0;
    fill_way = 1'b0; inv_valid = 1'b0; inv_idx = '0; inv_way = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: every set empty, victim way 0
    for (int s = 0; s < 128; s++) step("R2", 1, {20'hABCDE, 7'(s), 5'd0}, 0, N, 0, 0, 0, 0);

    // R6: lookup in the fill cycle still misses
    step("R6", 1, A, 1, A, 0, 0, 0, 0);
    // R3/R5: hit on way 0, victim now way 1
    step("R5", 1, A, 0, N, 0, 0, 0, 0);
    // R1: offset bits ignored, last tag bit and last index bit matter
    step("R1", 1, AL, 0, N, 0, 0, 0, 0);
    step("R1", 1, AT, 0, N, 0, 0, 0, 0);
    step("R1", 1, AI, 0, N, 0, 0, 0, 0);
    // R1: fill offset ignored; fill way 1 with B
    step("R5", 1, C, 1, 32'h1234507F, 1, 0, 0, 0);
    step("R3", 1, B, 0, N, 0, 0, 0, 0);
    // R7: hit way 0 flips LRU to way 1, then a miss keeps it
    step("R7", 1, A, 0, N, 0, 0, 0, 0);
    step("R7", 1, C, 0, N, 0, 0, 0, 0);
    step("R7", 1, C, 0, N, 0, 0, 0, 0);
    // R4: lookup disabled still reports victim, no hit
    step("R4", 0, A, 0, N, 0, 0, 0, 0);
    // R8: invalidate way 0 of set 3; way 1 kept, LRU kept
    step("R8", 0, A, 0, N, 0, 1, 3, 0);
    step("R8", 1, A, 0, N, 0, 0, 0, 0);
    step("R8", 1, B, 0, N, 0, 0, 0, 0);
    step("R8", 1, A, 0, N, 0, 0, 0, 0);
    // R9: fill and invalidate of the same line leave it valid
    step("R9", 0, A, 1, A, 0, 1, 3, 0);
    step("R9", 1, A, 0, N, 0, 0, 0, 0);
    // R9: hit on way 1 together with fill of way 0 in the same set
    step("R9", 1, B, 1, A, 0, 0, 0, 0);
    step("R9", 1, C, 0, N, 0, 0, 0, 0);
    // R10: neighbouring sets untouched
    step("R10", 1, 32'hABCDE080, 0, N, 0, 0, 0, 0);
    step("R10", 1, 32'hABCDE040, 0, N, 0, 0, 0, 0);

    // random traffic on a small pool of tags and sets
    tpool[0] = 20'hABCDE; tpool[1] = 20'h12345; tpool[2] = 20'h00000; tpool[3] = 20'hFFFFF;
    spool[0] = 0; spool[1] = 3; spool[2] = 64; spool[3] = 127;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] la;
      logic [31:0] fa;
      bit          fv;
      bit          fw;
      bit          iv;
      la = {tpool[$urandom % 4], 7'(spool[$urandom % 4]), 5'($urandom)};
      fa = {tpool[$urandom % 4], 7'(spool[$urandom % 4]), 5'($urandom)};
      fv = ($urandom % 3) == 0;
      fw = 1'($urandom);
      if (m_vld[~fw][fa[11:5]] && m_tag[~fw][fa[11:5]] == fa[31:12]) fw = ~fw;
      iv = ($urandom % 5) == 0;
      step("R3/R4/R10", 1'($urandom % 4 != 0), la, fv, fa, fw, iv, spool[$urandom % 4],
           1'($urandom));
    end
    idle();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule